// File: doc/BRIEF.md
# DMA Channel Ownership and Descriptor Register Block

This block is the software-facing register file of a multi-channel memory-to-memory DMA controller. Each channel has its own 4 KiB window. The window holds a control word, a programmable descriptor and a read-only copy of that descriptor. The descriptor has four parts: a config word, a byte count, a destination pointer and a source pointer. Software takes ownership of a channel by setting its claim bit. The first claim restores the descriptor to defaults. Software then fills in the descriptor and sets the run bit.

On a valid run request, the block issues a single-cycle start pulse to the data-moving engine. In the same cycle it latches the descriptor into the exec copy, which the engine reads. The engine later reports completion or failure with one-cycle pulses. The block turns these into sticky status bits and, where enabled, into per-channel interrupt lines.

Accesses are 32-bit or 64-bit. A 32-bit access reaches only the low half of a register, and read data is right-aligned.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every channel's control word reads 0, its next config reads 0x6600_0000, its other next and exec registers read 0, and all interrupt lines are low.
- R2: Next config is at offset 0x004, next byte count at 0x008, next destination at 0x010 and next source at 0x018. A 64-bit access (`bus_wide`=1) reads or writes all 64 bits. A 32-bit access writes only bits 31:0, keeps bits 63:32, and reads back bits 31:0 zero-extended.
- R3: The exec copies at 0x104 (config), 0x108 (bytes), 0x110 (destination) and 0x118 (source) are readable, and writes to them change nothing.
- R4: The control word is at 0x000, with claim at bit 0 and run at bit 1. A control write that moves claim from 0 to 1 sets next config to 0x6600_0000 (both 4-bit size fields, at 27:24 and 31:28, set to 6) and clears next bytes, destination and source. A write to an already claimed channel leaves them alone.
- R5: A control write that clears claim while run is 1 leaves claim at 1.
- R6: If the channel was unclaimed before the write, or the write clears claim while run is 0, then run reads back 0 and no start pulse is issued.
- R7: A control write to a claimed channel with run at 0 that sets claim and run has the following effects:
  - `eng_start` for that channel is high for the cycle of the write.
  - The exec copies equal the next registers from the following cycle.
  - The done status (bit 30) and error status (bit 31) are cleared.
  - An already running channel gets no second start.
- R8: A done pulse from the engine clears run and sets done status. An error pulse sets error status.
- R9: `irq[2n]` is high when done-enable (bit 14) and done status of channel n are both 1. `irq[2n+1]` is high when error-enable (bit 15) and error status are both 1. Other control bits read 0.
- R10: The channel is selected by address bits above bit 11. A channel index at or above `NUM_CH` reads 0, and writes to it have no effect.
- R11: An unmapped offset inside a channel window reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte address; bits above 11 select the channel |
| bus_wdata | input | 64 | Write data, right-aligned |
| bus_rdata | output | 64 | Combinational read data for `bus_addr` |
| eng_start | output | NUM_CH | One-cycle start pulse per channel |
| eng_done | input | NUM_CH | Completion pulse per channel |
| eng_err | input | NUM_CH | Failure pulse per channel |
| exec_cfg | output | 32*NUM_CH | Latched config word per channel |
| exec_bytes | output | 64*NUM_CH | Latched byte count per channel |
| exec_dst | output | 64*NUM_CH | Latched destination per channel |
| exec_src | output | 64*NUM_CH | Latched source per channel |
| irq | output | 2*NUM_CH | Done line 2n and error line 2n+1 per channel |

## Verification
The bench builds the block with its defaults: four channels and a 16-bit address. This leaves four channel-select bits, so indices from 4 to 15 exist on the bus but not in the block, and the rejection of such accesses can be exercised directly. With four channels, activity on channel 1 can also be checked against the interrupt and register state of channels 0, 2 and 3, which share the read multiplexer.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int SZ_DEF = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_wide,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [63:0]            bus_wdata,
  output logic [63:0]            bus_rdata,
  output logic [NUM_CH-1:0]      eng_start,
  input  logic [NUM_CH-1:0]      eng_done,
  input  logic [NUM_CH-1:0]      eng_err,
  output logic [32*NUM_CH-1:0]   exec_cfg,
  output logic [64*NUM_CH-1:0]   exec_bytes,
  output logic [64*NUM_CH-1:0]   exec_dst,
  output logic [64*NUM_CH-1:0]   exec_src,
  output logic [2*NUM_CH-1:0]    irq
);
  localparam int CHW = ADDR_W - 12;
  localparam logic [31:0] CFG_DEF = {4'(SZ_DEF), 4'(SZ_DEF), 24'h0};
  localparam logic [11:0] O_CTL = 12'h000, O_NCFG = 12'h004, O_NBYT = 12'h008,
                          O_NDST = 12'h010, O_NSRC = 12'h018, O_XCFG = 12'h104,
                          O_XBYT = 12'h108, O_XDST = 12'h110, O_XSRC = 12'h118;

  wire [CHW-1:0] bus_ch = bus_addr[ADDR_W-1:12];
  wire [11:0]    off    = bus_addr[11:0];

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic wide);
    return wide ? d : {old[63:32], d[31:0]};
  endfunction

  logic [63:0] rd_ch [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic        c_claim, c_run, c_die, c_eie, c_done, c_err;
    logic [31:0] n_cfg, x_cfg;
    logic [63:0] n_byt, n_dst, n_src, x_byt, x_dst, x_src;

    wire sel    = (bus_ch == CHW'(g));
    wire wr     = bus_wr & sel;
    wire wr_ctl = wr & (off == O_CTL);
    wire w_clm  = bus_wdata[0];
    wire w_run  = bus_wdata[1];
    wire rise   = wr_ctl & ~c_claim & w_clm;
    wire kill   = ~c_claim | (~c_run & ~w_clm);
    wire go     = wr_ctl & c_claim & ~c_run & w_clm & w_run;

    assign eng_start[g] = go;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_claim <= 1'b0; c_run <= 1'b0; c_die <= 1'b0;
        c_eie   <= 1'b0; c_done <= 1'b0; c_err <= 1'b0;
      end else begin
        if (wr_ctl) begin
          c_claim <= w_clm | c_run;
          c_run   <= kill ? 1'b0 : w_run;
          c_die   <= bus_wdata[14];
          c_eie   <= bus_wdata[15];
          c_done  <= bus_wdata[30];
          c_err   <= bus_wdata[31];
        end
        if (go) begin
          c_done <= 1'b0;
          c_err  <= 1'b0;
        end
        if (eng_done[g]) begin
          c_run  <= 1'b0;
          c_done <= 1'b1;
        end
        if (eng_err[g]) c_err <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_cfg <= CFG_DEF; n_byt <= '0; n_dst <= '0; n_src <= '0;
      end else if (rise) begin
        n_cfg <= CFG_DEF; n_byt <= '0; n_dst <= '0; n_src <= '0;
      end else if (wr) begin
        case (off)
          O_NCFG:  n_cfg <= bus_wdata[31:0];
          O_NBYT:  n_byt <= merge(n_byt, bus_wdata, bus_wide);
          O_NDST:  n_dst <= merge(n_dst, bus_wdata, bus_wide);
          O_NSRC:  n_src <= merge(n_src, bus_wdata, bus_wide);
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_cfg <= '0; x_byt <= '0; x_dst <= '0; x_src <= '0;
      end else if (go) begin
        x_cfg <= n_cfg; x_byt <= n_byt; x_dst <= n_dst; x_src <= n_src;
      end
    end

    always_comb begin
      case (off)
        O_CTL:   rd_ch[g] = {32'h0, c_err, c_done, 14'h0, c_eie, c_die, 12'h0, c_run, c_claim};
        O_NCFG:  rd_ch[g] = {32'h0, n_cfg};
        O_NBYT:  rd_ch[g] = n_byt;
        O_NDST:  rd_ch[g] = n_dst;
        O_NSRC:  rd_ch[g] = n_src;
        O_XCFG:  rd_ch[g] = {32'h0, x_cfg};
        O_XBYT:  rd_ch[g] = x_byt;
        O_XDST:  rd_ch[g] = x_dst;
        O_XSRC:  rd_ch[g] = x_src;
        default: rd_ch[g] = '0;
      endcase
    end

    assign exec_cfg[g*32 +: 32]   = x_cfg;
    assign exec_bytes[g*64 +: 64] = x_byt;
    assign exec_dst[g*64 +: 64]   = x_dst;
    assign exec_src[g*64 +: 64]   = x_src;
    assign irq[2*g]   = c_die & c_done;
    assign irq[2*g+1] = c_eie & c_err;
  end

  logic [63:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_ch == CHW'(i)) rd_sel = rd_ch[i];
  end

  assign bus_rdata = bus_wide ? rd_sel : {32'h0, rd_sel[31:0]};
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [1:0]           wbits,
  input logic [NUM_CH-1:0]    eng_start,
  input logic [NUM_CH-1:0]    eng_done,
  input logic [NUM_CH-1:0]    eng_err,
  input logic [64*NUM_CH-1:0] exec_bytes,
  input logic [2*NUM_CH-1:0]  irq
);
  localparam int CHW = ADDR_W - 12;
  wire [CHW-1:0] ch     = bus_addr[ADDR_W-1:12];
  wire           ctl_wr = bus_wr && (bus_addr[11:0] == 12'h000);

  p_far_channel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (int'(ch) >= NUM_CH)) |-> (eng_start == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    p_start_has_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[g] |-> (ctl_wr && ch == CHW'(g) && wbits == 2'b11));

    p_start_clears_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start[g] && !eng_done[g] && !eng_err[g]) |=> (!irq[2*g] && !irq[2*g+1]));

    p_exec_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_start[g] |=> $stable(exec_bytes[g*64 +: 64]));

    p_done_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[2*g]) |-> $past(ctl_wr && ch == CHW'(g)));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wbits(bus_wdata[1:0]), .eng_start(eng_start), .eng_done(eng_done),
  .eng_err(eng_err), .exec_bytes(exec_bytes), .irq(irq));

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_wide = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic [NUM_CH-1:0] eng_start, eng_done = '0, eng_err = '0;
  logic [32*NUM_CH-1:0] exec_cfg;
  logic [64*NUM_CH-1:0] exec_bytes, exec_dst, exec_src;
  logic [2*NUM_CH-1:0] irq;

  int checks = 0, fails = 0;
  logic [NUM_CH-1:0] start_seen;
  logic [63:0] v;

  always #2 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_done(eng_done), .eng_err(eng_err),
    .exec_cfg(exec_cfg), .exec_bytes(exec_bytes), .exec_dst(exec_dst),
    .exec_src(exec_src), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [11:0] off, input logic [63:0] d, input logic wide);
    @(negedge clk);
    bus_addr = {4'(ch), off}; bus_wdata = d; bus_wide = wide; bus_wr = 1'b1;
    #1 start_seen = eng_start;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [11:0] off, input logic wide, output logic [63:0] d);
    @(negedge clk);
    bus_addr = {4'(ch), off}; bus_wide = wide; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int ch, input logic is_err);
    @(negedge clk);
    if (is_err) eng_err[ch] = 1'b1; else eng_done[ch] = 1'b1;
    @(negedge clk);
    eng_err = '0; eng_done = '0;
  endtask

  task automatic t_reset;
    rd(0, 12'h000, 1, v); chk("R1 ctl", v, 64'h0);
    rd(2, 12'h004, 1, v); chk("R1 next cfg", v, 64'h6600_0000);
    rd(3, 12'h108, 1, v); chk("R1 exec bytes", v, 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
  endtask

  task automatic t_map;
    wr(0, 12'h008, 64'h1111_2222_3333_4444, 1);
    rd(0, 12'h008, 1, v); chk("R2 wide rw", v, 64'h1111_2222_3333_4444);
    wr(0, 12'h008, 64'hFFFF_FFFF_AAAA_BBBB, 0);
    rd(0, 12'h008, 1, v); chk("R2 narrow write", v, 64'h1111_2222_AAAA_BBBB);
    rd(0, 12'h008, 0, v); chk("R2 narrow read", v, 64'h0000_0000_AAAA_BBBB);
    wr(0, 12'h018, 64'h0123_4567_89AB_CDEF, 1);
    rd(0, 12'h018, 1, v); chk("R2 src", v, 64'h0123_4567_89AB_CDEF);
    wr(0, 12'h020, 64'hDEAD_BEEF_DEAD_BEEF, 1);
    rd(0, 12'h020, 1, v); chk("R11 unmapped read", v, 64'h0);
    rd(0, 12'h008, 1, v); chk("R11 no side effect", v, 64'h1111_2222_AAAA_BBBB);
  endtask

  task automatic t_claim;
    wr(0, 12'h000, 64'h3, 0);
    chk("R6 no start unclaimed", 64'(start_seen), 64'h0);
    rd(0, 12'h000, 0, v); chk("R6 run dropped", v, 64'h1);
    rd(0, 12'h008, 1, v); chk("R4 bytes reset", v, 64'h0);
    rd(0, 12'h018, 1, v); chk("R4 src reset", v, 64'h0);
    rd(0, 12'h004, 0, v); chk("R4 cfg reset", v, 64'h6600_0000);
    wr(0, 12'h004, 64'h2200_000C, 0);
    wr(0, 12'h000, 64'h1, 0);
    rd(0, 12'h004, 0, v); chk("R4 no reset when claimed", v, 64'h2200_000C);
    wr(0, 12'h000, 64'h2, 0);
    chk("R6 no start on release", 64'(start_seen), 64'h0);
    rd(0, 12'h000, 0, v); chk("R6 release ctl", v, 64'h0);
  endtask

  task automatic t_run;
    wr(1, 12'h000, 64'h1, 0);
    wr(1, 12'h004, 64'h3300_0004, 0);
    wr(1, 12'h008, 64'h40, 1);
    wr(1, 12'h010, 64'hA000_0000_0000_1000, 1);
    wr(1, 12'h018, 64'h0000_0000_8000_0000, 1);
    wr(1, 12'h108, 64'hFFFF, 1);
    rd(1, 12'h108, 1, v); chk("R3 exec write ignored", v, 64'h0);
    wr(1, 12'h000, 64'hC000_0001, 0);
    wr(1, 12'h000, 64'hC000_C003, 0);
    chk("R7 start pulse", 64'(start_seen), 64'h2);
    rd(1, 12'h000, 0, v); chk("R7 status cleared", v, 64'h0000_C003);
    rd(1, 12'h104, 0, v); chk("R7 exec cfg", v, 64'h3300_0004);
    rd(1, 12'h108, 1, v); chk("R7 exec bytes", v, 64'h40);
    rd(1, 12'h110, 1, v); chk("R7 exec dst", v, 64'hA000_0000_0000_1000);
    chk("R7 exec src port", exec_src[64 +: 64], 64'h0000_0000_8000_0000);
    wr(1, 12'h000, 64'h0000_C002, 0);
    chk("R7 no restart", 64'(start_seen), 64'h0);
    rd(1, 12'h000, 0, v); chk("R5 claim held", v, 64'h0000_C003);
    wr(1, 12'h110, 64'h0, 1);
    rd(1, 12'h110, 1, v); chk("R3 exec dst kept", v, 64'hA000_0000_0000_1000);
  endtask

  task automatic t_engine;
    pulse(1, 0);
    rd(1, 12'h000, 0, v); chk("R8 done", v, 64'h4000_C001);
    chk("R9 done irq", 64'(irq), 64'h04);
    pulse(1, 1);
    rd(1, 12'h000, 0, v); chk("R8 err", v, 64'hC000_C001);
    chk("R9 both irq", 64'(irq), 64'h0C);
    wr(1, 12'h000, 64'h4000_0001, 0);
    chk("R9 gated off", 64'(irq), 64'h00);
    wr(1, 12'h000, 64'h4000_4001, 0);
    chk("R9 done only", 64'(irq), 64'h04);
    wr(1, 12'h000, 64'h0000_C001, 0);
    chk("R9 cleared", 64'(irq), 64'h00);
  endtask

  task automatic t_channels;
    wr(2, 12'h008, 64'h55, 1);
    rd(2, 12'h008, 1, v); chk("R10 ch2", v, 64'h55);
    rd(3, 12'h008, 1, v); chk("R10 ch3 untouched", v, 64'h0);
    wr(5, 12'h008, 64'h99, 1);
    rd(5, 12'h008, 1, v); chk("R10 far read zero", v, 64'h0);
    wr(5, 12'h000, 64'h3, 0);
    chk("R10 far no start", 64'(start_seen), 64'h0);
    rd(1, 12'h008, 1, v); chk("R10 ch1 kept", v, 64'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_claim();
    t_run();
    t_engine();
    t_channels();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule